// File: doc/BRIEF.md
# Interlaced Video Line and Pixel Timing Generator

This block keeps the horizontal and vertical position of an interlaced composite video raster, 525 lines for NTSC or 625 lines for PAL. A pixel enable at 13.5 MHz advances a pixel counter, and the end of each line advances a line counter. A decoder turns the two counters into four outputs: an active-low composite sync with equalising and broad pulses in the vertical interval, a clamp/burst-position strobe, a blanking level and a field flag. The counters are also brought out to the ports.

In master mode the counters run freely. In slave mode they follow an external reference. A leading edge of the selected horizontal flag restarts the line, and a leading edge of the selected vertical flag returns the raster to line 1. The reference is either the dedicated HS/VS pins or the H/V flags that an upstream parser recovers from embedded timing codes. The block has no data stream, so there is no back-pressure. Every input is a plain level, sampled on cycles where the pixel enable is high.

Top module: `vtg_timing`

## Requirements
- R1: An asynchronous active-low reset sets the pixel counter to 0 and the line counter to 1, and clears the remembered H/V flag levels to low.
- R2: In master mode, each cycle with `pix_en` high moves the pixel counter up by one. When it is at or beyond the last pixel (857 NTSC, 863 PAL), it goes to 0 and the line advances. When the line is at or beyond the last line (525 NTSC, 625 PAL), the advance goes to line 1. Cycles with `pix_en` low change nothing.
- R3: In master mode, `hs_in`, `vs_in`, `code_h` and `code_v` have no effect on the counters.
- R4: In slave mode, a `pix_en` cycle whose selected H flag is high, when the selected H flag was low at the previous `pix_en` cycle, loads the pixel counter with 0 and advances the line as at a line end.
- R5: In slave mode, a `pix_en` cycle that sees a leading edge of the selected V flag loads line 1. This takes priority over any line advance in the same cycle. The pixel counter keeps its own rule.
- R6: `sync_src` = 0 selects `hs_in`/`vs_in`, and `sync_src` = 1 selects `code_h`/`code_v`. The unselected pair has no effect.
- R7: On normal lines, `csync_n` is low for pixels 0 to 62 and high elsewhere.
- R8: On equalising lines, `csync_n` is low for pixels 0–30 and for H to H+30, where H is half the line length. On broad lines it is low for pixels 0 to H−64 and H to 2H−64. The equalising lines are NTSC 1–3, 7–9, 264–266, 270–272 and PAL 3–5, 311–312, 316–318, 624–625. The broad lines are NTSC 4–6, 267–269 and PAL 1–2, 313–315.
- R9: In NTSC, `clamp` is high for pixels 72 to 107 on lines 10–263 and 273–525, and low elsewhere.
- R10: In PAL, `clamp` is high for pixels 72 to 107 on lines 6–310 and 319–623, and low elsewhere.
- R11: `blank` is high when the pixel is below 138 (NTSC) or 144 (PAL), or when the line lies outside the clamp line ranges of the selected standard.
- R12: `field` is high for lines 264 and above in NTSC, and for lines 314 and above in PAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_en | input | 1 | Pixel-rate enable (13.5 MHz) |
| std_pal | input | 1 | 0 = 525-line NTSC, 1 = 625-line PAL |
| slave_en | input | 1 | 0 = free-running, 1 = follow external reference |
| sync_src | input | 1 | Reference select: 0 = pins, 1 = embedded-code flags |
| hs_in | input | 1 | External horizontal reference, active high |
| vs_in | input | 1 | External vertical reference, active high |
| code_h | input | 1 | H flag recovered from embedded codes |
| code_v | input | 1 | V flag recovered from embedded codes |
| csync_n | output | 1 | Composite sync, active low |
| clamp | output | 1 | Clamp / burst-position strobe |
| blank | output | 1 | Blanking interval |
| field | output | 1 | Field identity, 1 = second field |
| pix_cnt | output | 10 | Current pixel in line |
| line_cnt | output | 10 | Current line, 1-based |

## Verification
A wrong counter value shows on `pix_cnt` or `line_cnt` in the same cycle the bad register loads. A missed or extra reload after an H or V leading edge therefore appears one clock after the sampling `pix_en`. Decoder faults stay hidden until the counters reach the line or pixel they affect. A wrong sync table entry surfaces only on that line, and a wrong line boundary only when the raster crosses it. For this reason the stimulus walks complete fields in both standards, using short slave-driven lines, and uses full-length lines for the pulse shapes in the vertical interval.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  typedef enum logic [1:0] {
    PULSE_NORMAL = 2'd0,
    PULSE_EQ     = 2'd1,
    PULSE_BROAD  = 2'd2
  } pulse_kind_e;

  // sync pulse shape used on a given line of the selected standard
  function automatic pulse_kind_e line_kind(input logic pal, input int ln);
    if (pal) begin
      if ((ln >= 1 && ln <= 2) || (ln >= 313 && ln <= 315)) return PULSE_BROAD;
      if ((ln >= 3 && ln <= 5) || (ln >= 311 && ln <= 312) ||
          (ln >= 316 && ln <= 318) || (ln >= 624 && ln <= 625)) return PULSE_EQ;
    end else begin
      if ((ln >= 4 && ln <= 6) || (ln >= 267 && ln <= 269)) return PULSE_BROAD;
      if ((ln >= 1 && ln <= 3) || (ln >= 7 && ln <= 9) ||
          (ln >= 264 && ln <= 266) || (ln >= 270 && ln <= 272)) return PULSE_EQ;
    end
    return PULSE_NORMAL;
  endfunction

  // lines carrying picture, clamp and burst
  function automatic logic picture_line(input logic pal, input int ln);
    if (pal) return (ln >= 6 && ln <= 310) || (ln >= 319 && ln <= 623);
    return (ln >= 10 && ln <= 263) || (ln >= 273 && ln <= 525);
  endfunction

  function automatic logic second_field(input logic pal, input int ln);
    return pal ? (ln >= 314) : (ln >= 264);
  endfunction

endpackage

// File: rtl/vtg_edge.sv
module vtg_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pix_en,
  input  logic [N-1:0] level,
  output logic [N-1:0] rise
);

  for (genvar i = 0; i < N; i++) begin : g_ch
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      prev_q <= 1'b0;
      else if (pix_en) prev_q <= level[i];
    end

    assign rise[i] = level[i] & ~prev_q;
  end

endmodule

// File: rtl/vtg_count.sv
module vtg_count #(
  parameter int PIX_W    = 10,
  parameter int LINE_W   = 10,
  parameter int NTSC_PPL = 858,
  parameter int PAL_PPL  = 864,
  parameter int NTSC_LPF = 525,
  parameter int PAL_LPF  = 625
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              std_pal,
  input  logic              slave_en,
  input  logic              h_rise,
  input  logic              v_rise,
  output logic [PIX_W-1:0]  pix_q,
  output logic [LINE_W-1:0] line_q
);

  localparam logic [PIX_W-1:0]  NTSC_LAST = PIX_W'(NTSC_PPL - 1);
  localparam logic [PIX_W-1:0]  PAL_LAST  = PIX_W'(PAL_PPL - 1);
  localparam logic [LINE_W-1:0] NTSC_END  = LINE_W'(NTSC_LPF);
  localparam logic [LINE_W-1:0] PAL_END   = LINE_W'(PAL_LPF);
  localparam logic [LINE_W-1:0] FIRST_LN  = LINE_W'(1);

  logic [PIX_W-1:0]  pix_last;
  logic [LINE_W-1:0] line_last;
  logic              h_sync, v_sync, end_of_line;

  assign pix_last    = std_pal ? PAL_LAST : NTSC_LAST;
  assign line_last   = std_pal ? PAL_END  : NTSC_END;
  assign h_sync      = slave_en & h_rise;
  assign v_sync      = slave_en & v_rise;
  assign end_of_line = h_sync | (pix_q >= pix_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q  <= '0;
      line_q <= FIRST_LN;
    end else if (pix_en) begin
      pix_q <= end_of_line ? '0 : pix_q + 1'b1;
      if (v_sync)           line_q <= FIRST_LN;
      else if (end_of_line) line_q <= (line_q >= line_last) ? FIRST_LN : line_q + 1'b1;
    end
  end

  // R2
  pix_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !slave_en && pix_q < pix_last) |=> (pix_q == $past(pix_q) + 1'b1));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(pix_q) && $stable(line_q)));

  // R4
  h_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && slave_en && h_rise) |=> (pix_q == '0));

  // R5
  v_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && slave_en && v_rise) |=> (line_q == FIRST_LN));

endmodule

// File: rtl/vtg_decode.sv
module vtg_decode #(
  parameter int PIX_W       = 10,
  parameter int LINE_W      = 10,
  parameter int NTSC_PPL    = 858,
  parameter int PAL_PPL     = 864,
  parameter int HS_W        = 63,
  parameter int EQ_W        = 31,
  parameter int BURST_START = 72,
  parameter int BURST_LEN   = 36,
  parameter int NTSC_HBLANK = 138,
  parameter int PAL_HBLANK  = 144
) (
  input  logic              std_pal,
  input  logic [PIX_W-1:0]  pix,
  input  logic [LINE_W-1:0] line,
  output logic              csync_n,
  output logic              clamp,
  output logic              blank,
  output logic              field
);
  import vtg_pkg::*;

  localparam logic [PIX_W-1:0] NTSC_LEN = PIX_W'(NTSC_PPL);
  localparam logic [PIX_W-1:0] PAL_LEN  = PIX_W'(PAL_PPL);
  localparam logic [PIX_W-1:0] HS_P     = PIX_W'(HS_W);
  localparam logic [PIX_W-1:0] EQ_P     = PIX_W'(EQ_W);
  localparam logic [PIX_W-1:0] B_FIRST  = PIX_W'(BURST_START);
  localparam logic [PIX_W-1:0] B_LAST   = PIX_W'(BURST_START + BURST_LEN - 1);
  localparam logic [PIX_W-1:0] NTSC_HB  = PIX_W'(NTSC_HBLANK);
  localparam logic [PIX_W-1:0] PAL_HB   = PIX_W'(PAL_HBLANK);

  logic [PIX_W-1:0] len, half, hb_end;
  pulse_kind_e      kind;
  logic             pic_ln, sync_low;

  always_comb begin
    len    = std_pal ? PAL_LEN : NTSC_LEN;
    half   = len >> 1;
    hb_end = std_pal ? PAL_HB : NTSC_HB;
    kind   = line_kind(std_pal, int'(line));
    pic_ln = picture_line(std_pal, int'(line));
    case (kind)
      PULSE_EQ:    sync_low = (pix < EQ_P) || (pix >= half && pix < half + EQ_P);
      PULSE_BROAD: sync_low = (pix < half - HS_P) || (pix >= half && pix < len - HS_P);
      default:     sync_low = (pix < HS_P);
    endcase
    csync_n = ~sync_low;
    clamp   = pic_ln && (pix >= B_FIRST) && (pix <= B_LAST);
    blank   = (pix < hb_end) || !pic_ln;
    field   = second_field(std_pal, int'(line));
  end

endmodule

// File: rtl/vtg_timing.sv
module vtg_timing #(
  parameter int PIX_W       = 10,
  parameter int LINE_W      = 10,
  parameter int NTSC_PPL    = 858,
  parameter int PAL_PPL     = 864,
  parameter int NTSC_LPF    = 525,
  parameter int PAL_LPF     = 625,
  parameter int HS_W        = 63,
  parameter int EQ_W        = 31,
  parameter int BURST_START = 72,
  parameter int BURST_LEN   = 36,
  parameter int NTSC_HBLANK = 138,
  parameter int PAL_HBLANK  = 144
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              std_pal,
  input  logic              slave_en,
  input  logic              sync_src,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic              code_h,
  input  logic              code_v,
  output logic              csync_n,
  output logic              clamp,
  output logic              blank,
  output logic              field,
  output logic [PIX_W-1:0]  pix_cnt,
  output logic [LINE_W-1:0] line_cnt
);

  localparam int REF_CH = 2;

  logic [REF_CH-1:0] ref_level, ref_rise;

  // bit 0 horizontal, bit 1 vertical
  assign ref_level = sync_src ? {code_v, code_h} : {vs_in, hs_in};

  vtg_edge #(.N(REF_CH)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pix_en (pix_en),
    .level  (ref_level),
    .rise   (ref_rise)
  );

  vtg_count #(
    .PIX_W(PIX_W), .LINE_W(LINE_W),
    .NTSC_PPL(NTSC_PPL), .PAL_PPL(PAL_PPL),
    .NTSC_LPF(NTSC_LPF), .PAL_LPF(PAL_LPF)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix_en   (pix_en),
    .std_pal  (std_pal),
    .slave_en (slave_en),
    .h_rise   (ref_rise[0]),
    .v_rise   (ref_rise[1]),
    .pix_q    (pix_cnt),
    .line_q   (line_cnt)
  );

  vtg_decode #(
    .PIX_W(PIX_W), .LINE_W(LINE_W),
    .NTSC_PPL(NTSC_PPL), .PAL_PPL(PAL_PPL),
    .HS_W(HS_W), .EQ_W(EQ_W),
    .BURST_START(BURST_START), .BURST_LEN(BURST_LEN),
    .NTSC_HBLANK(NTSC_HBLANK), .PAL_HBLANK(PAL_HBLANK)
  ) u_decode (
    .std_pal (std_pal),
    .pix     (pix_cnt),
    .line    (line_cnt),
    .csync_n (csync_n),
    .clamp   (clamp),
    .blank   (blank),
    .field   (field)
  );

  // R9
  clamp_sync_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clamp |-> csync_n);

  // R11
  clamp_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clamp |-> blank);

endmodule

// File: tb/vtg_timing_test.sv
`timescale 1ns/1ps
module vtg_timing_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_en = 1'b0, std_pal = 1'b0, slave_en = 1'b0, sync_src = 1'b0;
  logic hs_in = 1'b0, vs_in = 1'b0, code_h = 1'b0, code_v = 1'b0;
  logic csync_n, clamp, blank, field;
  logic [9:0] pix_cnt, line_cnt;

  always #2 clk = ~clk;

  vtg_timing uut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .std_pal(std_pal),
    .slave_en(slave_en), .sync_src(sync_src), .hs_in(hs_in), .vs_in(vs_in),
    .code_h(code_h), .code_v(code_v), .csync_n(csync_n), .clamp(clamp),
    .blank(blank), .field(field), .pix_cnt(pix_cnt), .line_cnt(line_cnt)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;
  string tag_cnt = "R1";

  // behavioural reference
  int m_pix = 0, m_line = 1, m_ph = 0, m_pv = 0;
  int hsel, vsel, last_pix, last_line;
  bit hr, vr, eol;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pix = 0; m_line = 1; m_ph = 0; m_pv = 0;
    end else if (pix_en) begin
      hsel = sync_src ? int'(code_h) : int'(hs_in);
      vsel = sync_src ? int'(code_v) : int'(vs_in);
      hr = slave_en && hsel == 1 && m_ph == 0;
      vr = slave_en && vsel == 1 && m_pv == 0;
      last_pix  = std_pal ? 863 : 857;
      last_line = std_pal ? 625 : 525;
      eol = hr || (m_pix >= last_pix);
      if (vr) m_line = 1;
      else if (eol) m_line = (m_line >= last_line) ? 1 : m_line + 1;
      m_pix = eol ? 0 : m_pix + 1;
      m_ph = hsel; m_pv = vsel;
    end
  end

  function automatic int kind_ref(input bit pal, input int ln);
    if (pal) begin
      if (ln == 1 || ln == 2 || (ln >= 313 && ln <= 315)) return 2;
      if ((ln >= 3 && ln <= 5) || ln == 311 || ln == 312 ||
          (ln >= 316 && ln <= 318) || ln == 624 || ln == 625) return 1;
      return 0;
    end
    if ((ln >= 4 && ln <= 6) || (ln >= 267 && ln <= 269)) return 2;
    if ((ln >= 1 && ln <= 3) || (ln >= 7 && ln <= 9) ||
        (ln >= 264 && ln <= 266) || (ln >= 270 && ln <= 272)) return 1;
    return 0;
  endfunction

  function automatic bit active_ref(input bit pal, input int ln);
    if (pal) return (ln >= 6 && ln <= 310) || (ln >= 319 && ln <= 623);
    return (ln >= 10 && ln <= 263) || (ln >= 273 && ln <= 525);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d (line %0d pix %0d)",
               tag, what, act, exp, m_line, m_pix);
    end
  endtask

  int e_cs, e_cl, e_bl, e_fd, k, h, len;

  always @(negedge clk) begin
    #1;
    if (!done) begin
      len = std_pal ? 864 : 858;
      h = len / 2;
      k = kind_ref(std_pal, m_line);
      if (k == 1)      e_cs = (m_pix < 31 || (m_pix >= h && m_pix < h + 31)) ? 0 : 1;
      else if (k == 2) e_cs = (m_pix < h - 63 || (m_pix >= h && m_pix < len - 63)) ? 0 : 1;
      else             e_cs = (m_pix < 63) ? 0 : 1;
      e_cl = (active_ref(std_pal, m_line) && m_pix >= 72 && m_pix <= 107) ? 1 : 0;
      e_bl = (m_pix < (std_pal ? 144 : 138) || !active_ref(std_pal, m_line)) ? 1 : 0;
      e_fd = (m_line >= (std_pal ? 314 : 264)) ? 1 : 0;
      chk(tag_cnt, "pix_cnt", int'(pix_cnt), m_pix);
      chk(tag_cnt, "line_cnt", int'(line_cnt), m_line);
      chk(k == 0 ? "R7" : "R8", "csync_n", int'(csync_n), e_cs);
      chk(std_pal ? "R10" : "R9", "clamp", int'(clamp), e_cl);
      chk("R11", "blank", int'(blank), e_bl);
      chk("R12", "field", int'(field), e_fd);
    end
  end

  // slave-mode lines of a fixed length, H leading edge on the first sample
  task automatic run_lines(input int n, input int llen, input bit junk);
    for (int l = 0; l < n; l++) begin
      for (int c = 0; c < llen; c++) begin
        @(negedge clk);
        if (sync_src) code_h = (c == 0); else hs_in = (c == 0);
        if (junk) begin
          if (sync_src) begin hs_in = c[1]; vs_in = c[2]; end
          else begin code_h = c[1]; code_v = c[2]; end
        end
      end
    end
  endtask

  initial begin
    tag_cnt = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2: NTSC free run with gaps in the enable
    tag_cnt = "R2";
    for (int c = 0; c < 1000; c++) begin
      @(negedge clk);
      pix_en = (c % 3) != 0;
    end
    // R3: reference pins and code flags toggle while in master mode
    tag_cnt = "R3";
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      pix_en = 1'b1;
      hs_in = (c % 50) == 0; vs_in = (c % 700) == 5;
      code_h = (c % 40) == 3; code_v = (c % 900) == 7;
    end
    // R5: slave on pins, V and H edge together
    @(negedge clk);
    hs_in = 0; vs_in = 0; code_h = 0; code_v = 0;
    slave_en = 1'b1; sync_src = 1'b0; tag_cnt = "R5";
    @(negedge clk); hs_in = 1; vs_in = 1;
    @(negedge clk); hs_in = 0; vs_in = 0;
    // R6: code flags toggle while pins are selected
    tag_cnt = "R6";
    run_lines(20, 112, 1'b1);
    code_h = 0; code_v = 0;
    // R4: short lines across a full NTSC frame and its wrap
    tag_cnt = "R4";
    run_lines(510, 112, 1'b0);
    // R5: V edge in mid-line, no H edge
    tag_cnt = "R5";
    repeat (30) @(negedge clk);
    vs_in = 1; @(negedge clk); vs_in = 0;
    repeat (50) @(negedge clk);
    // PAL: realign on code flags, then free run over full lines
    std_pal = 1'b1; sync_src = 1'b1;
    @(negedge clk); code_h = 1; code_v = 1;
    @(negedge clk); code_h = 0; code_v = 0;
    slave_en = 1'b0; tag_cnt = "R2";
    repeat (4400) @(negedge clk);
    // R6: code flags selected, pins carry junk, full PAL frame of short lines
    slave_en = 1'b1; tag_cnt = "R6";
    @(negedge clk); code_v = 1; code_h = 1;
    @(negedge clk); code_v = 0; code_h = 0;
    run_lines(630, 112, 1'b1);
    hs_in = 0; vs_in = 0;
    // R1: asynchronous reset in mid-run
    tag_cnt = "R1";
    #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    tag_cnt = "R2";
    repeat (100) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog run did not complete");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule